// File: doc/BRIEF.md
# Round-Robin Thread-Block Dispatcher

This block hands thread blocks to the cores of one cluster. It records which kernel each core is bound to. A core with no kernel, or whose kernel has no blocks left, asks an upstream kernel source for a new kernel. The dispatcher scans the cores in rotating order and issues at most one block per cycle, to the first core that can take one. It keeps a live-block count for each kernel and reports a kernel as finished once the kernel is fully dispatched and all of its blocks have retired.

Two binding policies are available, chosen by a mode pin:
- **Concurrent mode:** a core may take a new kernel as soon as its current kernel has nothing left to dispatch.
- **Exclusive mode:** the core must first drain, with no unfinished threads left, before it takes a new kernel.

A per-core admission tracker outside this block supplies the "block fits" flag. It receives release strobes from this block, one for each finished block. The kernel source is a valid/ready stream. A kernel id is taken on a cycle where `ksel_valid` and `ksel_ready` are both high. `ksel_ready` never depends on `ksel_valid`. A source may hold or withdraw an offer at any time, because nothing is consumed without the handshake.

Top module: `bd_dispatch`

## Requirements
- R1: At most one bit of `issue_strobe` is high in any cycle. The scan starts one core past the rotation pointer and wraps modulo the core count. The strobe goes to the first core in that order that is eligible.
- R2: The rotation pointer moves to the core that issued on each issue and holds otherwise. After reset it points at the last core, so the first scan begins at core 0.
- R3: A core is eligible only if it is bound, the blocks-remaining bit of its kernel (`kern_left[kid]`, one bit per kernel id) is 1, and its `core_fit` bit is 1. `issue_kern` carries that core's kernel id in the same cycle.
- R4: A core needs a kernel when it is unbound, or when its bound kernel has `kern_left` 0 and either `conc_mode` is 1 or its pending-thread count is 0. `ksel_ready` is high when any core needs a kernel. `ksel_core` names the first needing core in rotation order. On a handshake that core shows the new id on `core_kvld`/`core_kid` from the next cycle.
- R5: With `conc_mode` 0, a bound core whose kernel has `kern_left` 0 and whose pending count is nonzero does not request a kernel.
- R6: After each edge, `run_cnt` of a kernel equals its previous value, plus 1 if a block of it issued, minus the number of `fin_vld` bits whose `fin_kern` names it. Simultaneous finishes on several cores are all counted.
- R7: A kernel that has issued at least one block, has `run_cnt` 0 and has `kern_left` 0 raises `kern_done` for exactly one cycle, one edge later. At that same edge every core bound to it becomes unbound, unless a handshake rebinds that core.
- R8: `rel_vld` and `rel_kern` repeat `fin_vld` and `fin_kern` in the same cycle, as release requests to the admission tracker.
- R9: After reset no core is bound, all counts are 0 and `kern_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conc_mode | input | 1 | 1: concurrent kernel binding, 0: bind only after drain |
| kern_left | input | NKERN | Per kernel: blocks still to dispatch |
| core_pend | input | NCORE*PW | Per core: unfinished thread count |
| core_fit | input | NCORE | Per core: admission tracker says a block fits |
| ksel_valid | input | 1 | Kernel source offers an id |
| ksel_id | input | KW | Offered kernel id |
| ksel_ready | output | 1 | Some core wants a kernel |
| ksel_core | output | IW | Core that receives the offered kernel |
| fin_vld | input | NCORE | Per core: a block finished this cycle |
| fin_kern | input | NCORE*KW | Per core: kernel of the finished block |
| rel_vld | output | NCORE | Release strobe to admission tracker |
| rel_kern | output | NCORE*KW | Kernel of the released block |
| issue_strobe | output | NCORE | One-hot block issue |
| issue_kern | output | KW | Kernel of the issued block |
| core_kvld | output | NCORE | Per core: bound to a kernel |
| core_kid | output | NCORE*KW | Per core: bound kernel id |
| run_cnt | output | NKERN*CW | Per kernel: live blocks |
| kern_done | output | NKERN | Per kernel: completion pulse |

## Verification
The checker assumes the following about the environment:
- A finish is reported only for a kernel whose live count covers it, so counts never go below zero.
- `fin_kern` is meaningful only where `fin_vld` is set.
- A kernel's blocks-remaining bit is not raised again after its completion pulse while no core is bound to it.

The stimulus keeps a model of every kernel's live count and draws each cycle's finishes from that budget, so no count can underflow. The sweep runs both binding modes. It biases the blocks-remaining bits low for part of the run so that completions, unbinding and rebinding happen many times, and it resets once partway through.

// File: rtl/bd_pkg.sv
package bd_pkg;
  localparam int unsigned BD_CORES_DEF  = 4;
  localparam int unsigned BD_KERNS_DEF  = 4;
  localparam int unsigned BD_CNT_W_DEF  = 6;
  localparam int unsigned BD_PEND_W_DEF = 4;

  // index of the core sitting 'step' places after 'base', wrapping at n
  function automatic int unsigned bd_wrap(input int unsigned base,
                                          input int unsigned step,
                                          input int unsigned n);
    return (base + step) % n;
  endfunction
endpackage

// File: rtl/bd_rr_pick.sv
module bd_rr_pick
  import bd_pkg::*;
#(
  parameter int unsigned N = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic          hit,
  output logic [IW-1:0] sel
);
  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int unsigned i = 1; i <= N; i++) begin
      if (!hit && req[bd_wrap(int'(last), i, N)]) begin
        hit = 1'b1;
        sel = IW'(bd_wrap(int'(last), i, N));
      end
    end
  end
endmodule

// File: rtl/bd_core_slot.sv
module bd_core_slot #(
  parameter int unsigned NKERN = 4,
  localparam int unsigned KW = (NKERN > 1) ? $clog2(NKERN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conc_mode,
  input  logic [NKERN-1:0] kern_left,
  input  logic [NKERN-1:0] done_now,
  input  logic             drained,
  input  logic             fit,
  input  logic             bind_en,
  input  logic [KW-1:0]    bind_id,
  output logic             kvld,
  output logic [KW-1:0]    kid,
  output logic             need,
  output logic             elig
);
  logic          kvld_q;
  logic [KW-1:0] kid_q;
  logic          has_work;

  assign has_work = kvld_q && kern_left[kid_q];
  assign need     = !kvld_q || (!kern_left[kid_q] && (conc_mode || drained));
  assign elig     = has_work && fit;
  assign kvld     = kvld_q;
  assign kid      = kid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kvld_q <= 1'b0;
      kid_q  <= '0;
    end else if (bind_en) begin
      kvld_q <= 1'b1;
      kid_q  <= bind_id;
    end else if (kvld_q && done_now[kid_q]) begin
      kvld_q <= 1'b0;
    end
  end
endmodule

// File: rtl/bd_kern_track.sv
module bd_kern_track #(
  parameter int unsigned NCORE = 4,
  parameter int unsigned CW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             left,
  input  logic             issued,
  input  logic [NCORE-1:0] fin_hit,
  output logic [CW-1:0]    cnt,
  output logic             done_now,
  output logic             done_pulse
);
  logic          seen_q;
  logic [CW-1:0] cnt_q;
  logic          pulse_q;

  assign done_now   = seen_q && (cnt_q == '0) && !left;
  assign cnt        = cnt_q;
  assign done_pulse = pulse_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_q + CW'(issued) - CW'($countones(fin_hit));
      pulse_q <= done_now;
      if (done_now)    seen_q <= 1'b0;
      else if (issued) seen_q <= 1'b1;
    end
  end
endmodule

// File: rtl/bd_dispatch.sv
module bd_dispatch
  import bd_pkg::*;
#(
  parameter int unsigned NCORE = BD_CORES_DEF,
  parameter int unsigned NKERN = BD_KERNS_DEF,
  parameter int unsigned CW    = BD_CNT_W_DEF,
  parameter int unsigned PW    = BD_PEND_W_DEF,
  localparam int unsigned KW = (NKERN > 1) ? $clog2(NKERN) : 1,
  localparam int unsigned IW = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                conc_mode,
  input  logic [NKERN-1:0]    kern_left,
  input  logic [NCORE*PW-1:0] core_pend,
  input  logic [NCORE-1:0]    core_fit,
  input  logic                ksel_valid,
  input  logic [KW-1:0]       ksel_id,
  output logic                ksel_ready,
  output logic [IW-1:0]       ksel_core,
  input  logic [NCORE-1:0]    fin_vld,
  input  logic [NCORE*KW-1:0] fin_kern,
  output logic [NCORE-1:0]    rel_vld,
  output logic [NCORE*KW-1:0] rel_kern,
  output logic [NCORE-1:0]    issue_strobe,
  output logic [KW-1:0]       issue_kern,
  output logic [NCORE-1:0]    core_kvld,
  output logic [NCORE*KW-1:0] core_kid,
  output logic [NKERN*CW-1:0] run_cnt,
  output logic [NKERN-1:0]    kern_done
);
  logic [IW-1:0]    ptr_q;
  logic [NCORE-1:0] need_v, elig_v;
  logic [NKERN-1:0] done_now_v;
  logic             iss_hit, req_hit;
  logic [IW-1:0]    iss_sel, req_sel;
  logic             take;

  bd_rr_pick #(.N(NCORE)) u_iss_pick (
    .req(elig_v), .last(ptr_q), .hit(iss_hit), .sel(iss_sel));
  bd_rr_pick #(.N(NCORE)) u_req_pick (
    .req(need_v), .last(ptr_q), .hit(req_hit), .sel(req_sel));

  assign ksel_ready = req_hit;
  assign ksel_core  = req_sel;
  assign take       = ksel_valid && req_hit;
  assign rel_vld    = fin_vld;
  assign rel_kern   = fin_kern;

  always_comb begin
    issue_strobe = '0;
    issue_kern   = '0;
    if (iss_hit) begin
      issue_strobe[iss_sel] = 1'b1;
      issue_kern            = core_kid[int'(iss_sel)*KW +: KW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr_q <= IW'(NCORE - 1);
    else if (iss_hit) ptr_q <= iss_sel;
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    logic drained;
    assign drained = (core_pend[c*PW +: PW] == '0);
    bd_core_slot #(.NKERN(NKERN)) u_slot (
      .clk(clk), .rst_n(rst_n), .conc_mode(conc_mode),
      .kern_left(kern_left), .done_now(done_now_v),
      .drained(drained), .fit(core_fit[c]),
      .bind_en(take && (req_sel == IW'(c))), .bind_id(ksel_id),
      .kvld(core_kvld[c]), .kid(core_kid[c*KW +: KW]),
      .need(need_v[c]), .elig(elig_v[c]));
  end

  for (genvar k = 0; k < NKERN; k++) begin : g_kern
    logic [NCORE-1:0] hit_v;
    for (genvar c = 0; c < NCORE; c++) begin : g_hit
      assign hit_v[c] = fin_vld[c] && (fin_kern[c*KW +: KW] == KW'(k));
    end
    bd_kern_track #(.NCORE(NCORE), .CW(CW)) u_trk (
      .clk(clk), .rst_n(rst_n), .left(kern_left[k]),
      .issued(iss_hit && (issue_kern == KW'(k))),
      .fin_hit(hit_v), .cnt(run_cnt[k*CW +: CW]),
      .done_now(done_now_v[k]), .done_pulse(kern_done[k]));
  end
endmodule

// File: rtl/bd_dispatch_chk.sv
module bd_dispatch_chk #(
  parameter int unsigned NCORE = 4,
  parameter int unsigned NKERN = 4,
  parameter int unsigned CW    = 6,
  parameter int unsigned PW    = 4,
  localparam int unsigned KW = (NKERN > 1) ? $clog2(NKERN) : 1,
  localparam int unsigned IW = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                conc_mode,
  input logic [NKERN-1:0]    kern_left,
  input logic [NCORE*PW-1:0] core_pend,
  input logic [NCORE-1:0]    core_fit,
  input logic                ksel_valid,
  input logic [KW-1:0]       ksel_id,
  input logic                ksel_ready,
  input logic [IW-1:0]       ksel_core,
  input logic [NCORE-1:0]    fin_vld,
  input logic [NCORE-1:0]    issue_strobe,
  input logic [NCORE-1:0]    core_kvld,
  input logic [NCORE*KW-1:0] core_kid,
  input logic [NKERN*CW-1:0] run_cnt,
  input logic [NKERN-1:0]    kern_done
);
  p_one_issue_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(issue_strobe));

  p_cnt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_strobe == '0 && fin_vld == '0) |=> $stable(run_cnt));

  for (genvar c = 0; c < NCORE; c++) begin : g_c
    p_issue_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
      issue_strobe[c] |-> (core_fit[c] && core_kvld[c] && kern_left[core_kid[c*KW +: KW]]));

    p_bind_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ksel_valid && ksel_ready && ksel_core == IW'(c)) |=>
        (core_kvld[c] && core_kid[c*KW +: KW] == $past(ksel_id)));

    p_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!conc_mode && core_kvld[c] && core_pend[c*PW +: PW] != '0) |->
        !(ksel_ready && ksel_core == IW'(c)));
  end

  for (genvar k = 0; k < NKERN; k++) begin : g_k
    p_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      kern_done[k] |-> (run_cnt[k*CW +: CW] == '0 && !$past(kern_left[k])));

    p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      kern_done[k] |=> !kern_done[k]);
  end
endmodule

bind bd_dispatch bd_dispatch_chk #(.NCORE(NCORE), .NKERN(NKERN), .CW(CW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .conc_mode(conc_mode), .kern_left(kern_left),
  .core_pend(core_pend), .core_fit(core_fit), .ksel_valid(ksel_valid),
  .ksel_id(ksel_id), .ksel_ready(ksel_ready), .ksel_core(ksel_core),
  .fin_vld(fin_vld), .issue_strobe(issue_strobe), .core_kvld(core_kvld),
  .core_kid(core_kid), .run_cnt(run_cnt), .kern_done(kern_done));

// File: tb/test_bd_dispatch.sv
module test_bd_dispatch;
  localparam int CLK_NS = 10;
  localparam int NC = 4;
  localparam int NK = 4;
  localparam int CW = 6;
  localparam int PW = 4;
  localparam int KW = 2;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conc_mode = 1'b0;
  logic [NK-1:0] kern_left = '0;
  logic [NC*PW-1:0] core_pend = '0;
  logic [NC-1:0] core_fit = '0;
  logic ksel_valid = 1'b0;
  logic [KW-1:0] ksel_id = '0;
  logic ksel_ready;
  logic [IW-1:0] ksel_core;
  logic [NC-1:0] fin_vld = '0;
  logic [NC*KW-1:0] fin_kern = '0;
  logic [NC-1:0] rel_vld;
  logic [NC*KW-1:0] rel_kern;
  logic [NC-1:0] issue_strobe;
  logic [KW-1:0] issue_kern;
  logic [NC-1:0] core_kvld;
  logic [NC*KW-1:0] core_kid;
  logic [NK*CW-1:0] run_cnt;
  logic [NK-1:0] kern_done;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  bit m_kv[NC];
  int m_kid[NC];
  int m_ptr;
  int m_cnt[NK];
  bit m_seen[NK];
  bit m_done[NK];

  always #(CLK_NS/2) clk = ~clk;

  bd_dispatch #(.NCORE(NC), .NKERN(NK), .CW(CW), .PW(PW)) i_bd_dispatch (
    .clk(clk), .rst_n(rst_n), .conc_mode(conc_mode), .kern_left(kern_left),
    .core_pend(core_pend), .core_fit(core_fit), .ksel_valid(ksel_valid),
    .ksel_id(ksel_id), .ksel_ready(ksel_ready), .ksel_core(ksel_core),
    .fin_vld(fin_vld), .fin_kern(fin_kern), .rel_vld(rel_vld), .rel_kern(rel_kern),
    .issue_strobe(issue_strobe), .issue_kern(issue_kern), .core_kvld(core_kvld),
    .core_kid(core_kid), .run_cnt(run_cnt), .kern_done(kern_done));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < NC; c++) begin m_kv[c] = 0; m_kid[c] = 0; end
    for (int k = 0; k < NK; k++) begin m_cnt[k] = 0; m_seen[k] = 0; m_done[k] = 0; end
    m_ptr = NC - 1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; fin_vld = '0; ksel_valid = 1'b0; kern_left = '0; core_fit = '0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R9 core_kvld after reset", int'(core_kvld), 0);
    chk("R9 run_cnt after reset", int'(run_cnt), 0);
    chk("R9 kern_done after reset", int'(kern_done), 0);
    chk("R9 issue_strobe idle", int'(issue_strobe), 0);
    chk("R9 ksel_ready unbound", int'(ksel_ready), 1);
    chk("R2 first scan starts at core 0", int'(ksel_core), 0);
  endtask

  task automatic cycle_run(input int bias);
    int budget[NK];
    int e_iss, e_req, c, k;
    int fcount[NK];
    bit done_now[NK];
    @(negedge clk);
    for (int kk = 0; kk < NK; kk++) begin
      kern_left[kk] = ($urandom_range(0, 3) < bias);
      budget[kk] = m_cnt[kk];
      fcount[kk] = 0;
    end
    for (int cc = 0; cc < NC; cc++) begin
      core_pend[cc*PW +: PW] = ($urandom_range(0, 2) == 0) ? '0 : PW'($urandom_range(1, 15));
      core_fit[cc] = ($urandom_range(0, 3) != 0);
      fin_vld[cc] = 1'b0;
      fin_kern[cc*KW +: KW] = KW'($urandom_range(0, NK-1));
      if ($urandom_range(0, 1) == 1 && budget[fin_kern[cc*KW +: KW]] > 0) begin
        fin_vld[cc] = 1'b1;
        budget[fin_kern[cc*KW +: KW]]--;
        fcount[fin_kern[cc*KW +: KW]]++;
      end
    end
    ksel_valid = ($urandom_range(0, 2) != 0);
    ksel_id = KW'($urandom_range(0, NK-1));
    #1;
    e_iss = -1; e_req = -1;
    for (int i = 1; i <= NC; i++) begin
      c = (m_ptr + i) % NC;
      if (e_iss < 0 && m_kv[c] && kern_left[m_kid[c]] && core_fit[c]) e_iss = c;
      if (e_req < 0 && (!m_kv[c] || (!kern_left[m_kid[c]] &&
          (conc_mode || core_pend[c*PW +: PW] == '0)))) e_req = c;
    end
    for (int cc = 0; cc < NC; cc++) begin
      chk("R1 issue_strobe rotation", int'(issue_strobe[cc]), int'(cc == e_iss));
      chk("R8 rel_vld mirror", int'(rel_vld[cc]), int'(fin_vld[cc]));
      if (fin_vld[cc]) chk("R8 rel_kern mirror", int'(rel_kern[cc*KW +: KW]), int'(fin_kern[cc*KW +: KW]));
      chk("R7 core_kvld", int'(core_kvld[cc]), int'(m_kv[cc]));
      if (m_kv[cc]) chk("R4 core_kid", int'(core_kid[cc*KW +: KW]), m_kid[cc]);
    end
    if (e_iss >= 0) chk("R3 issue_kern", int'(issue_kern), m_kid[e_iss]);
    if (conc_mode) chk("R4 ksel_ready", int'(ksel_ready), int'(e_req >= 0));
    else           chk("R5 ksel_ready drain wait", int'(ksel_ready), int'(e_req >= 0));
    if (e_req >= 0) chk("R4 ksel_core", int'(ksel_core), e_req);
    for (int kk = 0; kk < NK; kk++) begin
      chk("R6 run_cnt", int'(run_cnt[kk*CW +: CW]), m_cnt[kk]);
      chk("R7 kern_done", int'(kern_done[kk]), int'(m_done[kk]));
    end
    // model advance
    for (int kk = 0; kk < NK; kk++)
      done_now[kk] = m_seen[kk] && m_cnt[kk] == 0 && !kern_left[kk];
    for (int cc = 0; cc < NC; cc++) begin
      if (ksel_valid && e_req == cc) begin m_kv[cc] = 1; m_kid[cc] = int'(ksel_id); end
      else if (m_kv[cc] && done_now[m_kid[cc]]) m_kv[cc] = 0;
    end
    for (int kk = 0; kk < NK; kk++) begin
      k = kk;
      m_cnt[k] = m_cnt[k] - fcount[k];
      if (e_iss >= 0 && i_kid_of(e_iss) == k) begin m_cnt[k]++; m_seen[k] = 1; end
      if (done_now[k]) m_seen[k] = 0;
      m_done[k] = done_now[k];
    end
    if (e_iss >= 0) m_ptr = e_iss;
  endtask

  function automatic int i_kid_of(input int cc);
    return m_kid_snap[cc];
  endfunction

  int m_kid_snap[NC];

  task automatic run_phase(input bit mode, input int bias, input int n);
    conc_mode = mode;
    for (int j = 0; j < n; j++) begin
      for (int cc = 0; cc < NC; cc++) m_kid_snap[cc] = m_kid[cc];
      cycle_run(bias);
    end
  endtask

  initial begin
    model_reset();
    do_reset();
    run_phase(1'b0, 3, 1500);
    run_phase(1'b0, 1, 1500);
    run_phase(1'b1, 3, 1500);
    run_phase(1'b1, 1, 1500);
    do_reset();
    run_phase(1'b1, 2, 1000);
    run_phase(1'b0, 2, 1000);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R0 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule